// File: doc/BRIEF.md
# Multi-FIFO Interprocessor Mailbox

This block lets several processors, called users, pass 32-bit messages to one another through a small bank of hardware FIFOs. All of them reach the block over one simple register bus. A processor sends a message by writing it to the message register of a FIFO. The receiving processor reads that same register to take the oldest word. Two per-FIFO registers report the fill state of each queue: a full flag and a message count.

Each user has a bank of three registers: an interrupt status register, an enable-set register and an enable-clear register. Each FIFO owns two adjacent event bits in that bank. The even bit is the new-message event. The odd bit is the room-available (not-full) event. Status bits are cleared by writing 1 to them. Each user has one level interrupt line. The line is high while any status bit that is also enabled is set. The number of FIFOs, the number of users and the FIFO depth are parameters.

Top module: `mbx_hub`

## Requirements
- R1: After reset every FIFO is empty, every status and enable bit is zero, and every interrupt line is low.
- R2: Address 0x000 reads the constant revision value. Any other address that is not listed here, and any address not aligned to 4 bytes, reads zero. A write to such an address changes nothing.
- R3: Writing the message register of FIFO m at 0x040 + 4*m appends the word to FIFO m. Reading that register returns and removes the oldest word, in first-in first-out order. No other FIFO is affected.
- R4: A write to a full FIFO is discarded. A read from an empty FIFO returns zero and leaves the FIFO unchanged.
- R5: The full register of FIFO m at 0x080 + 4*m reads 1 when the FIFO holds DEPTH words and 0 otherwise.
- R6: The count register of FIFO m at 0x0C0 + 4*m reads the number of words queued in FIFO m.
- R7: The status register of user u is at 0x104 + 0x10*u. Bit 2*m is set on every clock edge at which FIFO m held at least one word in the previous cycle. This happens for every user, whatever its enables.
- R8: Status bit 2*m+1 of user u is set on a clock edge at which FIFO m was not full. It is set only if enable bit 2*m+1 of that user was already 1.
- R9: Writing 1 to a status bit clears it at that clock edge, and zero bits in the write leave their bits alone. If the condition behind the bit still holds, the bit is set again at the following edge.
- R10: Writing 0x108 + 0x10*u sets the enable bits written as 1. Writing 0x10C + 0x10*u clears the enable bits written as 1. Zero bits have no effect. Both addresses read back the current enable word.
- R11: Interrupt line u is high exactly while the status word and the enable word of user u have a common bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Byte address of the register accessed |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe for one cycle; a message read pops at the clock edge |
| rd_data | output | DATA_W | Read data, valid in the same cycle as rd_en, zero when idle |
| irq | output | NUM_USERS | Level interrupt, one per user |

## Verification
Each FIFO is filled one word at a time until one word more than its depth has been written. After every write, every non-message register is swept. This separates count, full and event behaviour at each fill level, and it shows that the extra word is discarded. The FIFOs are then drained past empty, which tests word order and the zero read of an empty queue. Between the fill and the drain, acknowledges with mixed bit patterns separate a bit that stays clear from one that sets again because its condition still holds. Enables given only to some users show that the not-full event is gated per user while the new-message event is not. Unaligned and unmapped accesses made while data is queued must neither return data nor move a FIFO.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_REV,
        K_MSG,
        K_FULL,
        K_CNT,
        K_STAT,
        K_ENSET,
        K_ENCLR
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
    } reg_sel_t;

    localparam logic [15:0] MSG_BASE  = 16'h0040;
    localparam logic [15:0] USER_BASE = 16'h0100;

    // Map a byte address to a register kind and a FIFO or user index.
    function automatic reg_sel_t decode_addr(input logic [15:0] a,
                                             input int unsigned nf,
                                             input int unsigned nu);
        reg_sel_t   sel;
        logic [15:0] rel;
        sel.kind = K_NONE;
        sel.idx  = '0;
        rel      = '0;
        if (a[1:0] == 2'b00) begin
            if (a == 16'h0000) begin
                sel.kind = K_REV;
            end else if (a >= MSG_BASE && a < USER_BASE) begin
                if (32'(a[5:2]) < nf) begin
                    sel.idx = {4'b0000, a[5:2]};
                    case (a[7:6])
                        2'd1:    sel.kind = K_MSG;
                        2'd2:    sel.kind = K_FULL;
                        2'd3:    sel.kind = K_CNT;
                        default: sel.kind = K_NONE;
                    endcase
                end
            end else if (a >= USER_BASE) begin
                rel = a - USER_BASE;
                if (32'(rel[15:4]) < nu) begin
                    sel.idx = rel[11:4];
                    case (rel[3:0])
                        4'h4:    sel.kind = K_STAT;
                        4'h8:    sel.kind = K_ENSET;
                        4'hC:    sel.kind = K_ENCLR;
                        default: sel.kind = K_NONE;
                    endcase
                end
            end
        end
        return sel;
    endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic              full,
    output logic [CNT_W-1:0]  count
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wptr;
        logic [PTR_W-1:0]             rptr;
        logic [CNT_W-1:0]             count;
    } fifo_state_t;

    fifo_state_t state_d, state_q;
    logic        do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        state_d = state_q;
        do_push = push && (state_q.count != CNT_W'(DEPTH));
        do_pop  = pop && (state_q.count != '0);
        if (do_push) begin
            state_d.mem[state_q.wptr] = push_data;
            state_d.wptr              = ptr_inc(state_q.wptr);
        end
        if (do_pop) begin
            state_d.rptr = ptr_inc(state_q.rptr);
        end
        case ({do_push, do_pop})
            2'b10:   state_d.count = state_q.count + 1'b1;
            2'b01:   state_d.count = state_q.count - 1'b1;
            default: state_d.count = state_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign head_data = (state_q.count != '0) ? state_q.mem[state_q.rptr] : '0;
    assign full      = (state_q.count == CNT_W'(DEPTH));
    assign count     = state_q.count;

    // R4: occupancy never exceeds the depth
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.count <= CNT_W'(DEPTH));

    // R4: a push into a full queue is discarded
    a_r4_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> (count == $past(count)));

    // R4: a pop from an empty queue moves nothing
    a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == '0) |=> (count == '0 && state_q.rptr == $past(state_q.rptr)));

    // R3: an accepted push adds exactly one word
    a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
    parameter int NUM_FIFOS = 4,
    localparam int EV_W = 2 * NUM_FIFOS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FIFOS-1:0] has_msg,
    input  logic [NUM_FIFOS-1:0] not_full,
    input  logic                 stat_wr,
    input  logic                 en_set_wr,
    input  logic                 en_clr_wr,
    input  logic [EV_W-1:0]      wdata,
    output logic [EV_W-1:0]      status,
    output logic [EV_W-1:0]      enable,
    output logic                 irq
);

    typedef struct packed {
        logic [EV_W-1:0] status;
        logic [EV_W-1:0] enable;
    } user_state_t;

    function automatic logic [EV_W-1:0] odd_bits();
        logic [EV_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_FIFOS; i++) m[2*i+1] = 1'b1;
        return m;
    endfunction

    localparam logic [EV_W-1:0] ODD_MASK = odd_bits();

    user_state_t     state_d, state_q;
    logic [EV_W-1:0] raise;
    logic [EV_W-1:0] ack;

    always_comb begin
        state_d = state_q;
        raise   = '0;
        for (int m = 0; m < NUM_FIFOS; m++) begin
            raise[2*m]   = has_msg[m];
            raise[2*m+1] = not_full[m] & state_q.enable[2*m+1];
        end
        ack            = stat_wr ? wdata : '0;
        state_d.status = (state_q.status | raise) & ~ack;
        if (en_set_wr)      state_d.enable = state_q.enable | wdata;
        else if (en_clr_wr) state_d.enable = state_q.enable & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign status = state_q.status;
    assign enable = state_q.enable;
    assign irq    = |(state_q.status & state_q.enable);

    // R9: acknowledged bits are clear after the write edge
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((status & $past(wdata)) == '0));

    // R10: set-register ones end up enabled
    a_r10_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        en_set_wr |=> (($past(wdata) & ~enable) == '0));

    // R10: clear-register ones end up disabled
    a_r10_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr_wr |=> ((enable & $past(wdata)) == '0));

    // R8: a not-full bit can only rise where its enable was already on
    a_r8_nf_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ODD_MASK & ~$past(enable)) == '0));

endmodule

// File: rtl/mbx_hub.sv
module mbx_hub
    import mbx_pkg::*;
#(
    parameter int          NUM_FIFOS = 4,
    parameter int          NUM_USERS = 2,
    parameter int          DEPTH     = 4,
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 12,
    parameter logic [31:0] REV_ID    = 32'h0000_0100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_USERS-1:0] irq
);

    localparam int EV_W  = 2 * NUM_FIFOS;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int FI_W  = (NUM_FIFOS > 1) ? $clog2(NUM_FIFOS) : 1;
    localparam int UI_W  = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1;

    reg_sel_t                         sel;
    logic [NUM_FIFOS-1:0][DATA_W-1:0] head;
    logic [NUM_FIFOS-1:0]             full;
    logic [NUM_FIFOS-1:0][CNT_W-1:0]  cnt;
    logic [NUM_FIFOS-1:0]             has_msg;
    logic [NUM_USERS-1:0][EV_W-1:0]   stat;
    logic [NUM_USERS-1:0][EV_W-1:0]   en;
    logic [FI_W-1:0]                  fi;
    logic [UI_W-1:0]                  ui;

    assign sel = decode_addr(16'(addr), NUM_FIFOS, NUM_USERS);
    assign fi  = sel.idx[FI_W-1:0];
    assign ui  = sel.idx[UI_W-1:0];

    for (genvar g = 0; g < NUM_FIFOS; g++) begin : g_fifo
        mbx_fifo #(
            .DEPTH  (DEPTH),
            .DATA_W (DATA_W)
        ) i_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (wr_en && sel.kind == K_MSG && sel.idx == 8'(g)),
            .push_data (wr_data),
            .pop       (rd_en && sel.kind == K_MSG && sel.idx == 8'(g)),
            .head_data (head[g]),
            .full      (full[g]),
            .count     (cnt[g])
        );
        assign has_msg[g] = (cnt[g] != '0);
    end

    for (genvar g = 0; g < NUM_USERS; g++) begin : g_user
        mbx_user_irq #(
            .NUM_FIFOS (NUM_FIFOS)
        ) i_user (
            .clk       (clk),
            .rst_n     (rst_n),
            .has_msg   (has_msg),
            .not_full  (~full),
            .stat_wr   (wr_en && sel.kind == K_STAT  && sel.idx == 8'(g)),
            .en_set_wr (wr_en && sel.kind == K_ENSET && sel.idx == 8'(g)),
            .en_clr_wr (wr_en && sel.kind == K_ENCLR && sel.idx == 8'(g)),
            .wdata     (wr_data[EV_W-1:0]),
            .status    (stat[g]),
            .enable    (en[g]),
            .irq       (irq[g])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (sel.kind)
                K_REV:           rd_data = DATA_W'(REV_ID);
                K_MSG:           rd_data = head[fi];
                K_FULL:          rd_data = DATA_W'(full[fi]);
                K_CNT:           rd_data = DATA_W'(cnt[fi]);
                K_STAT:          rd_data = DATA_W'(stat[ui]);
                K_ENSET, K_ENCLR: rd_data = DATA_W'(en[ui]);
                default:         rd_data = '0;
            endcase
        end
    end

endmodule

// File: tb/test_mbx_hub.sv
`timescale 1ns/1ps
module test_mbx_hub;

    localparam int          NF    = 4;
    localparam int          NU    = 2;
    localparam int          DEPTH = 4;
    localparam logic [31:0] REV   = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [NU-1:0] irq;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    mbx_hub #(
        .NUM_FIFOS (NF),
        .NUM_USERS (NU),
        .DEPTH     (DEPTH),
        .DATA_W    (32),
        .ADDR_W    (12),
        .REV_ID    (REV)
    ) i_mbx_hub (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .irq     (irq)
    );

    // Reference model of the register state
    logic [31:0] m_mem [NF][DEPTH];
    int          m_head [NF];
    int          m_cnt  [NF];
    logic [7:0]  m_stat [NU];
    logic [7:0]  m_en   [NU];

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string tag, input int a);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%h: got %h expected %h", tag, a, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int a);
        int u, o, m;
        if (a == 0) return REV;
        if (a % 4 != 0) return 32'h0;
        if (a >= 'h40 && a < 'h40 + 4*NF) begin
            m = (a - 'h40) / 4;
            return (m_cnt[m] > 0) ? m_mem[m][m_head[m]] : 32'h0;
        end
        if (a >= 'h80 && a < 'h80 + 4*NF) return (m_cnt[(a-'h80)/4] == DEPTH) ? 32'h1 : 32'h0;
        if (a >= 'hC0 && a < 'hC0 + 4*NF) return 32'(m_cnt[(a-'hC0)/4]);
        if (a >= 'h100 && a < 'h100 + 16*NU) begin
            u = (a - 'h100) / 16;
            o = (a - 'h100) % 16;
            if (o == 4) return 32'(m_stat[u]);
            if (o == 8 || o == 12) return 32'(m_en[u]);
        end
        return 32'h0;
    endfunction

    function automatic string tag_of(input int a);
        if (a >= 'h40 && a < 'h80) return "R3";
        if (a >= 'h80 && a < 'hC0) return "R5";
        if (a >= 'hC0 && a < 'h100) return "R6";
        if (a >= 'h100 && (a % 16) == 4) return "R7";
        if (a >= 'h100 && (a % 16) >= 8) return "R10";
        return "R2";
    endfunction

    task automatic step(input bit wr, input bit rd, input int a, input logic [31:0] d);
        logic [7:0] ns;
        for (int u = 0; u < NU; u++) begin
            ns = m_stat[u];
            for (int m = 0; m < NF; m++) begin
                if (m_cnt[m] > 0) ns[2*m] = 1'b1;
                if (m_cnt[m] < DEPTH && m_en[u][2*m+1]) ns[2*m+1] = 1'b1;
            end
            if (wr && a == 'h104 + 16*u) ns = ns & ~d[7:0];
            m_stat[u] = ns;
            if (wr && a == 'h108 + 16*u) m_en[u] = m_en[u] | d[7:0];
            if (wr && a == 'h10C + 16*u) m_en[u] = m_en[u] & ~d[7:0];
        end
        for (int m = 0; m < NF; m++) begin
            if (wr && a == 'h40 + 4*m && m_cnt[m] < DEPTH) begin
                m_mem[m][(m_head[m] + m_cnt[m]) % DEPTH] = d;
                m_cnt[m]++;
            end
            if (rd && a == 'h40 + 4*m && m_cnt[m] > 0) begin
                m_head[m] = (m_head[m] + 1) % DEPTH;
                m_cnt[m]--;
            end
        end
    endtask

    // One bus cycle: drive after the falling edge, sample before the rising edge.
    task automatic op(input bit wr, input bit rd, input int a, input logic [31:0] d,
                      input string tag);
        logic [NU-1:0] ei;
        @(negedge clk);
        addr = a[11:0]; wr_en = wr; rd_en = rd; wr_data = d;
        #1;
        if (rd) check(rd_data, exp_read(a), tag, a);
        for (int u = 0; u < NU; u++) ei[u] = |(m_stat[u] & m_en[u]);
        check(32'(irq), 32'(ei), "R11", a);
        @(posedge clk);
        step(wr, rd, a, d);
        #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < 'h140; a += 4) begin
            if (!(a >= 'h40 && a < 'h80))
                op(1'b0, 1'b1, a, 32'h0, (tag == "") ? tag_of(a) : tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int m = 0; m < NF; m++) begin
            m_head[m] = 0; m_cnt[m] = 0;
            for (int k = 0; k < DEPTH; k++) m_mem[m][k] = '0;
        end
        for (int u = 0; u < NU; u++) begin m_stat[u] = '0; m_en[u] = '0; end

        repeat (3) @(posedge clk);
        #1;
        check(32'(irq), 32'h0, "R1", 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every register at its reset value, empty FIFOs read zero
        sweep("R1");
        for (int m = 0; m < NF; m++) op(1'b0, 1'b1, 'h40 + 4*m, 32'h0, "R1");

        // R3 R5 R6 R7: fill each FIFO one past its depth, sweeping each level
        for (int m = 0; m < NF; m++) begin
            for (int k = 0; k <= DEPTH; k++) begin
                op(1'b1, 1'b0, 'h40 + 4*m, 32'hA000_0000 + 32'(m*256 + k), "R4");
                sweep("");
            end
        end

        // R2: unaligned and unmapped accesses return zero and move nothing
        op(1'b0, 1'b1, 'h41, 32'h0, "R2");
        op(1'b1, 1'b0, 'h42, 32'h1234_5678, "R2");
        op(1'b0, 1'b1, 'h50, 32'h0, "R2");
        op(1'b0, 1'b1, 'h100, 32'h0, "R2");
        op(1'b0, 1'b1, 'h124, 32'h0, "R2");
        sweep("R2");

        // R9: zero write is harmless; ack of a live event comes back next edge
        op(1'b1, 1'b0, 'h104, 32'h0, "R9");
        op(1'b0, 1'b1, 'h104, 32'h0, "R9");
        op(1'b1, 1'b0, 'h104, 32'h0000_0055, "R9");
        op(1'b0, 1'b1, 'h104, 32'h0, "R9");
        op(1'b0, 1'b1, 'h104, 32'h0, "R9");
        op(1'b0, 1'b1, 'h114, 32'h0, "R9");

        // R10 R11: new-message enable on user 0, not-full enables on user 1
        op(1'b1, 1'b0, 'h108, 32'h0000_0001, "R10");
        op(1'b1, 1'b0, 'h118, 32'hFFFF_FFAA, "R10");
        sweep("");
        // R8: room in FIFO 1 raises its not-full bit only for user 1
        op(1'b0, 1'b1, 'h44, 32'h0, "R3");
        op(1'b0, 1'b0, 0, 32'h0, "R8");
        sweep("R8");

        // R3 R4: drain every FIFO past empty
        for (int m = 0; m < NF; m++) begin
            for (int k = 0; k <= DEPTH; k++)
                op(1'b0, 1'b1, 'h40 + 4*m, 32'h0, (k < DEPTH) ? "R3" : "R4");
            sweep("");
        end

        // R9: ack everything; new-message bits stay clear, enabled not-full return
        op(1'b1, 1'b0, 'h104, 32'h0000_00FF, "R9");
        op(1'b1, 1'b0, 'h114, 32'h0000_00FF, "R9");
        op(1'b0, 1'b1, 'h114, 32'h0, "R9");
        sweep("R9");

        // R10: partial clear, zero clear, then full clear and ack
        op(1'b1, 1'b0, 'h11C, 32'h0000_000F, "R10");
        op(1'b1, 1'b0, 'h11C, 32'h0, "R10");
        sweep("R10");
        op(1'b1, 1'b0, 'h10C, 32'h0000_00FF, "R10");
        op(1'b1, 1'b0, 'h11C, 32'h0000_00FF, "R10");
        op(1'b1, 1'b0, 'h104, 32'h0000_00FF, "R9");
        op(1'b1, 1'b0, 'h114, 32'h0000_00FF, "R9");
        sweep("R11");

        // R3: interleaved traffic across two FIFOs keeps order per queue
        op(1'b1, 1'b0, 'h48, 32'h1111_0001, "R3");
        op(1'b1, 1'b0, 'h4C, 32'h2222_0001, "R3");
        op(1'b1, 1'b0, 'h48, 32'h1111_0002, "R3");
        op(1'b0, 1'b1, 'h4C, 32'h0, "R3");
        op(1'b0, 1'b1, 'h48, 32'h0, "R3");
        op(1'b0, 1'b1, 'h48, 32'h0, "R3");
        sweep("");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule